// File: doc/BRIEF.md
# Double-Buffered Convolution Coefficient Register File

This block is the host-side configuration store for a 3x3 image convolver. The host presents one write per cycle as an address and a 16-bit data word. The 3-bit address is a command. Some commands load the row-length register, the microcode word or the configuration word. Two commands stream nine 8-bit coefficients into one of two banks. Two more commands pick which bank feeds the datapath, and one command does nothing.

The two coefficient banks work as a ping-pong pair. While a frame is being processed (`proc_active` high), the host can refill the idle bank and then switch banks with a single select command. A write aimed at the live bank during a frame is dropped, so the kernel in use can never be torn. Coefficients within a bank are addressed by an internal tap index rather than by the host. Consecutive strobes to the same bank address fill taps 0 through 8 in order.

The write interface is valid/ready. `wr_ready` is held high at all times, so the block never applies back-pressure. Every cycle with `wr_valid` high is one accepted command. Dropping a protected coefficient write does not stall the host. The write is simply discarded.

Top module: `conv_coef_regfile`

## Requirements
- R1: After reset, bank 0 is selected. Row length, microcode, all configuration fields and all eighteen coefficients are zero, and `wr_ready` is high.
- R2: `wr_ready` is high in every cycle, and each cycle with `wr_valid` high is executed as exactly one command.
- R3: Command 000 loads `row_len` from `wr_data[9:0]` and ignores bits 15:10. Command 001 loads all 16 bits of `wr_data` into `ucode`. Both appear on the outputs in the cycle after the write.
- R4: Command 100 loads the configuration word from `wr_data[8:0]` and ignores bits 15:9. The fields are placed as follows: bit 0 is `casc_ext`, bits 2:1 are `in_delay`, bit 3 is `in_signed`, bit 4 is `coef_signed`, bits 6:5 are `round_mode`, and bits 8:7 are `casc_shift`.
- R5: Command 010 writes `wr_data[7:0]` into bank 0, and command 011 writes it into bank 1, at the current tap index. Bits 15:8 are ignored.
- R6: The tap index is 0 for a coefficient write whose address differs from the previous write's address, or that is the first write after reset. Otherwise it is one more than the previous index, and it wraps from 8 to 0. The index advances even when the write is dropped.
- R7: Command 101 selects bank 0 and command 110 selects bank 1. `bank_sel` and `coef_out` show the new bank from the cycle after the command.
- R8: While `proc_active` is high, a coefficient write to the currently selected bank is dropped, and a write to the other bank is stored. While `proc_active` is low, writes to both banks are stored.
- R9: Command 111, and any cycle with `wr_valid` low, leaves every output unchanged.
- R10: `coef_out[8k+7:8k]` carries tap k of the selected bank, for k from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host command valid |
| wr_ready | output | 1 | Always high; no back-pressure |
| wr_addr | input | 3 | Command address |
| wr_data | input | 16 | Command data word |
| proc_active | input | 1 | High while a frame is processed; gates live-bank writes |
| coef_out | output | 72 | Nine taps of the selected bank, tap k at bits 8k+7:8k |
| bank_sel | output | 1 | Selected bank |
| row_len | output | 10 | Row length |
| ucode | output | 16 | Microcode word |
| casc_ext | output | 1 | Cascade source select field |
| in_delay | output | 2 | Input delay count field |
| in_signed | output | 1 | Input data is two's complement |
| coef_signed | output | 1 | Coefficients are two's complement |
| round_mode | output | 2 | Output rounding field |
| casc_shift | output | 2 | Cascade input shift field |

## Verification
The bench targets the tap index at its edges. It wraps after the ninth write, restarts when a no-op or another address intervenes, and advances across a dropped write. An index that failed to wrap or to restart would put coefficients in the wrong taps, and that would show up on `coef_out` once the bank is selected. Protection is exercised in both directions while `proc_active` is high. A design that checked the wrong bank would either corrupt the live kernel or refuse to refill the idle one. Protection is also exercised right after a bank switch, where a design that used the pending select instead of the current one would go wrong. Upper data bits are driven high on the row, configuration and coefficient commands, so a design that leaks those bits shows wrong field values.

// File: rtl/conv_coef_pkg.sv
package conv_coef_pkg;

  typedef enum logic [2:0] {
    CMD_ROWLEN = 3'b000,
    CMD_UCODE  = 3'b001,
    CMD_BANK0  = 3'b010,
    CMD_BANK1  = 3'b011,
    CMD_CONFIG = 3'b100,
    CMD_USE0   = 3'b101,
    CMD_USE1   = 3'b110,
    CMD_NOP    = 3'b111
  } cmd_e;

  // configuration word, MSB first so that a cast from data[8:0] lines up
  typedef struct packed {
    logic [1:0] casc_shift;   // 8:7
    logic [1:0] round_mode;   // 6:5
    logic       coef_signed;  // 4
    logic       in_signed;    // 3
    logic [1:0] in_delay;     // 2:1
    logic       casc_ext;     // 0
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/conv_cmd_decode.sv
module conv_cmd_decode
  import conv_coef_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] addr,
  output logic       ld_row,
  output logic       ld_ucode,
  output logic       ld_cfg,
  output logic [1:0] ld_bank,
  output logic [1:0] use_bank
);

  always_comb begin
    ld_row   = 1'b0;
    ld_ucode = 1'b0;
    ld_cfg   = 1'b0;
    ld_bank  = 2'b00;
    use_bank = 2'b00;
    if (valid) begin
      unique case (cmd_e'(addr))
        CMD_ROWLEN: ld_row      = 1'b1;
        CMD_UCODE:  ld_ucode    = 1'b1;
        CMD_BANK0:  ld_bank[0]  = 1'b1;
        CMD_BANK1:  ld_bank[1]  = 1'b1;
        CMD_CONFIG: ld_cfg      = 1'b1;
        CMD_USE0:   use_bank[0] = 1'b1;
        CMD_USE1:   use_bank[1] = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/conv_tap_index.sv
module conv_tap_index
  import conv_coef_pkg::*;
#(
  parameter int TAPS  = 9,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [2:0]       addr,
  input  logic             is_coef,
  output logic [IDX_W-1:0] idx
);

  logic [2:0]       last_addr;
  logic [IDX_W-1:0] next_cnt;

  // index in use for the write presented this cycle
  assign idx = (last_addr == addr) ? next_cnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= CMD_NOP;
      next_cnt  <= '0;
    end else if (valid) begin
      last_addr <= addr;
      if (!is_coef)
        next_cnt <= '0;
      else if (idx == IDX_W'(TAPS - 1))
        next_cnt <= '0;
      else
        next_cnt <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/conv_coef_bank.sv
module conv_coef_bank #(
  parameter int COEF_W = 8,
  parameter int TAPS   = 9,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [COEF_W-1:0]        din,
  output logic [TAPS*COEF_W-1:0]   taps
);

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [COEF_W-1:0] tap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tap_q <= '0;
      else if (we && idx == IDX_W'(k))
        tap_q <= din;
    end
    assign taps[k*COEF_W +: COEF_W] = tap_q;
  end

endmodule

// File: rtl/conv_coef_regfile.sv
module conv_coef_regfile
  import conv_coef_pkg::*;
#(
  parameter int COEF_W  = 8,
  parameter int TAPS    = 9,
  parameter int ROW_W   = 10,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(TAPS),
  localparam int BANK_W = TAPS * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              proc_active,
  output logic [BANK_W-1:0] coef_out,
  output logic              bank_sel,
  output logic [ROW_W-1:0]  row_len,
  output logic [DATA_W-1:0] ucode,
  output logic              casc_ext,
  output logic [1:0]        in_delay,
  output logic              in_signed,
  output logic              coef_signed,
  output logic [1:0]        round_mode,
  output logic [1:0]        casc_shift
);

  logic             ld_row, ld_ucode, ld_cfg;
  logic [1:0]       ld_bank, use_bank, bank_we;
  logic [IDX_W-1:0] tap_idx;
  logic [BANK_W-1:0] bank_taps [2];
  cfg_t             cfg_q;

  assign wr_ready = 1'b1;

  conv_cmd_decode u_dec (
    .valid    (wr_valid),
    .addr     (wr_addr),
    .ld_row   (ld_row),
    .ld_ucode (ld_ucode),
    .ld_cfg   (ld_cfg),
    .ld_bank  (ld_bank),
    .use_bank (use_bank)
  );

  conv_tap_index #(.TAPS(TAPS)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (wr_valid),
    .addr    (wr_addr),
    .is_coef (|ld_bank),
    .idx     (tap_idx)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    // live bank is write-protected for the length of a frame
    assign bank_we[b] = ld_bank[b] && !(proc_active && (bank_sel == 1'(b)));

    conv_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[b]),
      .idx   (tap_idx),
      .din   (wr_data[COEF_W-1:0]),
      .taps  (bank_taps[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel <= 1'b0;
      row_len  <= '0;
      ucode    <= '0;
      cfg_q    <= '0;
    end else begin
      if (use_bank[0])   bank_sel <= 1'b0;
      else if (use_bank[1]) bank_sel <= 1'b1;
      if (ld_row)   row_len <= wr_data[ROW_W-1:0];
      if (ld_ucode) ucode   <= wr_data;
      if (ld_cfg)   cfg_q   <= cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  assign coef_out    = bank_taps[bank_sel];
  assign casc_ext    = cfg_q.casc_ext;
  assign in_delay    = cfg_q.in_delay;
  assign in_signed   = cfg_q.in_signed;
  assign coef_signed = cfg_q.coef_signed;
  assign round_mode  = cfg_q.round_mode;
  assign casc_shift  = cfg_q.casc_shift;

endmodule

// File: rtl/conv_coef_regfile_chk.sv
module conv_coef_regfile_chk #(
  parameter int BANK_W = 72,
  parameter int ROW_W  = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              proc_active,
  input logic [BANK_W-1:0] coef_out,
  input logic              bank_sel,
  input logic [ROW_W-1:0]  row_len,
  input logic [DATA_W-1:0] ucode
);

  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  // R3
  row_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == 3'b000 |=> row_len == $past(wr_data[ROW_W-1:0]));

  // R3
  ucode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == 3'b001 |=> ucode == $past(wr_data));

  // R7
  use0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == 3'b101 |=> !bank_sel);

  // R7
  use1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == 3'b110 |=> bank_sel);

  // R8
  live_bank_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && proc_active && wr_addr == {2'b01, bank_sel} |=> $stable(coef_out) && $stable(bank_sel));

  // R9
  nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == 3'b111 |=> $stable(coef_out) && $stable(bank_sel) && $stable(row_len) && $stable(ucode));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(coef_out) && $stable(bank_sel) && $stable(row_len) && $stable(ucode));

endmodule

bind conv_coef_regfile conv_coef_regfile_chk #(
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .proc_active (proc_active),
  .coef_out    (coef_out),
  .bank_sel    (bank_sel),
  .row_len     (row_len),
  .ucode       (ucode)
);

// File: tb/conv_coef_regfile_test.sv
module conv_coef_regfile_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_addr = 3'b111;
  logic [15:0] wr_data = '0;
  logic        proc_active = 1'b0;
  logic        wr_ready;
  logic [71:0] coef_out;
  logic        bank_sel;
  logic [9:0]  row_len;
  logic [15:0] ucode;
  logic        casc_ext, in_signed, coef_signed;
  logic [1:0]  in_delay, round_mode, casc_shift;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_coef_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .proc_active(proc_active),
    .coef_out(coef_out), .bank_sel(bank_sel), .row_len(row_len), .ucode(ucode),
    .casc_ext(casc_ext), .in_delay(in_delay), .in_signed(in_signed),
    .coef_signed(coef_signed), .round_mode(round_mode), .casc_shift(casc_shift)
  );

  // reference model state
  int m_bank [2][9];
  int m_sel, m_row, m_uc, m_cfg, m_last, m_next;
  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic model_reset();
    for (int b = 0; b < 2; b++) for (int k = 0; k < 9; k++) m_bank[b][k] = 0;
    m_sel = 0; m_row = 0; m_uc = 0; m_cfg = 0; m_last = 7; m_next = 0;
  endtask

  task automatic model_step(bit v, int a, int d, bit act);
    int ix, b;
    if (!v) return;
    if (a == 2 || a == 3) begin
      b  = a - 2;
      ix = (m_last == a) ? m_next : 0;
      if (!(act && m_sel == b)) m_bank[b][ix] = d % 256;
      m_next = (ix == 8) ? 0 : ix + 1;
    end else begin
      m_next = 0;
      case (a)
        0: m_row = d % 1024;
        1: m_uc  = d;
        4: m_cfg = d % 512;
        5: m_sel = 0;
        6: m_sel = 1;
        default: ;
      endcase
    end
    m_last = a;
  endtask

  task automatic chk(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [71:0] exp_c;
    for (int k = 0; k < 9; k++) exp_c[k*8 +: 8] = 8'(m_bank[m_sel][k]);
    chk("wr_ready", wr_ready, 1);
    chk("bank_sel", bank_sel, m_sel);
    chk("row_len", row_len, m_row);
    chk("ucode", ucode, m_uc);
    chk("casc_ext", casc_ext, m_cfg & 1);
    chk("in_delay", in_delay, (m_cfg >> 1) & 3);
    chk("in_signed", in_signed, (m_cfg >> 3) & 1);
    chk("coef_signed", coef_signed, (m_cfg >> 4) & 1);
    chk("round_mode", round_mode, (m_cfg >> 5) & 3);
    chk("casc_shift", casc_shift, (m_cfg >> 7) & 3);
    for (int k = 0; k < 9; k++)
      chk($sformatf("coef_out tap %0d", k), coef_out[k*8 +: 8], exp_c[k*8 +: 8]);
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic step(bit v, int a, int d, bit act);
    wr_valid = v; wr_addr = 3'(a); wr_data = 16'(d); proc_active = act;
    @(posedge clk);
    model_step(v, a, d, act);
    @(negedge clk);
    compare_all();
  endtask

  task automatic fill(int a, int base, bit act);
    for (int k = 0; k < 9; k++) step(1, a, 16'hFF00 | (base + k), act);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    cur_req = "R3";
    step(1, 0, 16'hFC2A, 0);
    step(1, 1, 16'hBEEF, 0);
    cur_req = "R4";
    step(1, 4, 16'hFE00 | 9'b10_10_1_0_11_1, 0);
    step(1, 4, 16'hAA00 | 9'b01_01_0_1_10_0, 0);

    cur_req = "R5";
    fill(2, 8'h10, 0);
    cur_req = "R10";
    step(0, 7, 0, 0);
    cur_req = "R6";
    step(1, 2, 16'hAAE1, 0);
    step(1, 2, 16'h55E2, 0);
    step(1, 7, 0, 0);
    step(1, 2, 16'h00E3, 0);
    cur_req = "R5";
    fill(3, 8'h30, 0);
    cur_req = "R7";
    step(1, 6, 0, 0);
    cur_req = "R10";
    step(0, 0, 0, 0);

    cur_req = "R8";
    step(1, 3, 16'h0077, 1);
    step(1, 3, 16'h0078, 1);
    step(1, 2, 16'h0099, 1);
    cur_req = "R6";
    step(1, 3, 16'h00C1, 1);
    step(1, 3, 16'h00C2, 1);
    cur_req = "R7";
    step(1, 5, 0, 1);
    cur_req = "R8";
    step(1, 3, 16'h00D0, 1);
    step(1, 2, 16'h00D1, 1);
    step(1, 2, 16'h00D2, 0);
    cur_req = "R9";
    step(1, 7, 16'hFFFF, 1);
    step(0, 0, 16'h1234, 0);
    step(0, 3, 16'h1234, 1);

    cur_req = "R2";
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 65535),
           $urandom_range(0, 1) == 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s watchdog actual=hung expected=done", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule